// File: doc/BRIEF.md
# Fast/normal interrupt request arbiter

This block decides, at each instruction boundary, whether the processor leaves its current flow for an interrupt handler, and which of two handlers it enters. Two active-low level request lines come in: a fast line and a normal line. A mode input selects how they are sampled. When it is low, the lines are treated as asynchronous and each passes through one register before the decision logic sees it. When it is high, they are taken as already synchronous and that register is bypassed.

The block holds the two mask flags from the processor status word. The F flag gates the fast line and the I flag gates the normal line. Privileged software may rewrite the flags; writes from user mode are dropped.

On entry the block does four things:
- It raises a one-cycle take pulse.
- It updates the masks. Fast entry sets both F and I; normal entry sets I only.
- It presents an exception code and a mode-switch request.
- It presents a return-address adjustment of 4 for the handler's return.

These outputs hold until the core acknowledges the switch. No further entry is possible until then.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, take, mode_req, exc_code and ret_adj are all zero, and both f_mask and i_mask are 1.
- R2: A request is a low level on its line. It is acted on only at an edge where eoi is 1; a request without eoi produces no take.
- R3: With sync_mode high, a request that is low in the same cycle as eoi is taken at that edge. take is high in the following cycle.
- R4: With sync_mode low, a line must already have been low at the previous edge to be seen. A request that first goes low in the eoi cycle is not taken at that edge.
- R5: A fast request is ignored while f_mask is 1, and a normal request is ignored while i_mask is 1.
- R6: When both lines are eligible at the same boundary, the fast interrupt is taken. exc_code encodes 2'b10 for fast, 2'b01 for normal and 2'b00 for none.
- R7: Taking the fast interrupt sets both f_mask and i_mask. Taking the normal interrupt sets i_mask and leaves f_mask unchanged.
- R8: mask_wr loads f_mask from mask_wdata[1] and i_mask from mask_wdata[0], but only when priv is 1. With priv at 0 the write is ignored.
- R9: take lasts exactly one cycle. After it, mode_req stays at 1 and exc_code stays constant until a cycle with ack. No new take occurs while mode_req is 1. ack is ignored when mode_req is 0.
- R10: ret_adj is 4 while mode_req is 1, and 0 otherwise.
- R11: When a mask write and an entry fall on the same edge, the flags the entry sets win over the written values. The entry decision itself uses the flags from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_req_n | input | 1 | Fast interrupt request, active low level |
| norm_req_n | input | 1 | Normal interrupt request, active low level |
| sync_mode | input | 1 | 1: requests synchronous, no extra register; 0: one synchronizing register |
| eoi | input | 1 | End-of-instruction strobe, the decision point |
| priv | input | 1 | Core is in a privileged mode |
| mask_wr | input | 1 | Mask flag write strobe |
| mask_wdata | input | 2 | Write data, bit 1 = F, bit 0 = I |
| ack | input | 1 | Core has completed the mode switch |
| take | output | 1 | One-cycle pulse on interrupt entry |
| exc_code | output | 2 | Exception taken: 10 fast, 01 normal, 00 none |
| mode_req | output | 1 | Mode-switch request, held until ack |
| ret_adj | output | RET_W | Return-address subtraction for the handler |
| f_mask | output | 1 | F flag, fast interrupt disabled when 1 |
| i_mask | output | 1 | I flag, normal interrupt disabled when 1 |

## Verification
The assertions assume every input is stable across each rising edge and free of X once reset is released. They also assume the request lines stay settled for the whole cycle in which they are sampled, so a single register is an adequate synchronizer model.

The bench meets these assumptions by changing inputs only on the falling edge. It draws requests as levels that persist for several cycles. It raises ack only while a switch is pending, and now and then drops it into idle cycles as well to exercise the ignore rule.

sync_mode is changed only between decisions, at points where a change of mode cannot meet a stale synchronizer value in the same cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int NUM_LINES = 2;
  localparam int LINE_NORM = 0;
  localparam int LINE_FAST = 1;

  typedef enum logic [1:0] {
    EXC_NONE = 2'b00,
    EXC_NORM = 2'b01,
    EXC_FAST = 2'b10
  } exc_code_e;

  typedef struct packed {
    logic f;
    logic i;
  } mask_t;

  // Next mask value: an allowed write replaces the flags, then entry sets OR in.
  function automatic mask_t next_masks(input mask_t cur, input logic wr_ok,
                                       input logic [1:0] wdata,
                                       input logic set_f, input logic set_i);
    mask_t m;
    m = wr_ok ? mask_t'(wdata) : cur;
    m.f = m.f | set_f;
    m.i = m.i | set_i;
    return m;
  endfunction

  // Pick the winning line from eligible levels; fast dominates.
  function automatic exc_code_e pick_winner(input logic fast_ok, input logic norm_ok);
    if (fast_ok)      return EXC_FAST;
    else if (norm_ok) return EXC_NORM;
    else              return EXC_NONE;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_mode,
  input  logic [N-1:0] req_n,
  output logic [N-1:0] level
);

  logic [N-1:0] q;
  logic         seen_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) q[g] <= 1'b0;
      else        q[g] <= ~req_n[g];
    end
    assign level[g] = sync_mode ? ~req_n[g] : q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R4: in asynchronous mode the level seen is the line as it stood one edge earlier
  p_async_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !sync_mode) |-> (level == $past(~req_n)));

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
(
  input  logic [NUM_LINES-1:0] level,
  input  logic                 f_mask,
  input  logic                 i_mask,
  output logic                 fast_ok,
  output logic                 norm_ok,
  output exc_code_e            winner
);

  always_comb begin
    fast_ok = level[LINE_FAST] & ~f_mask;
    norm_ok = level[LINE_NORM] & ~i_mask;
    winner  = pick_winner(fast_ok, norm_ok);
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [1:0] wdata,
  input  logic       set_f,
  input  logic       set_i,
  output logic       f_mask,
  output logic       i_mask
);

  mask_t m_q;

  always_ff @(posedge clk) begin
    if (!rst_n) m_q <= '{f: 1'b1, i: 1'b1};
    else        m_q <= next_masks(m_q, wr_ok, wdata, set_f, set_i);
  end

  assign f_mask = m_q.f;
  assign i_mask = m_q.i;

  // R8: without an allowed write or an entry, the flags hold
  p_hold_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !set_f && !set_i) |=> ($stable(f_mask) && $stable(i_mask)));
  // R7 / R11: an entry always leaves I set, whatever the write says
  p_entry_sets_i_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> i_mask);
  p_fast_sets_f_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_f |=> (f_mask && i_mask));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int RET_W      = 4,
  parameter int RET_OFFSET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_req_n,
  input  logic             norm_req_n,
  input  logic             sync_mode,
  input  logic             eoi,
  input  logic             priv,
  input  logic             mask_wr,
  input  logic [1:0]       mask_wdata,
  input  logic             ack,
  output logic             take,
  output logic [1:0]       exc_code,
  output logic             mode_req,
  output logic [RET_W-1:0] ret_adj,
  output logic             f_mask,
  output logic             i_mask
);

  localparam logic [RET_W-1:0] RET_VAL = RET_W'(RET_OFFSET);

  function automatic logic [RET_W-1:0] ret_value(input logic active);
    return active ? RET_VAL : '0;
  endfunction

  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] req_n_vec;
  logic                 fast_ok, norm_ok;
  exc_code_e            winner;
  logic                 entry, set_f, set_i, wr_ok;
  logic                 busy_q, take_q;
  exc_code_e            code_q;

  always_comb begin
    req_n_vec            = '1;
    req_n_vec[LINE_FAST] = fast_req_n;
    req_n_vec[LINE_NORM] = norm_req_n;
  end

  irq_sync #(.N(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_mode(sync_mode),
    .req_n    (req_n_vec),
    .level    (lvl)
  );

  irq_select u_sel (
    .level  (lvl),
    .f_mask (f_mask),
    .i_mask (i_mask),
    .fast_ok(fast_ok),
    .norm_ok(norm_ok),
    .winner (winner)
  );

  assign entry = eoi && !busy_q && (winner != EXC_NONE);
  assign set_f = entry && (winner == EXC_FAST);
  assign set_i = entry;
  assign wr_ok = mask_wr && priv;

  irq_mask_reg u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ok (wr_ok),
    .wdata (mask_wdata),
    .set_f (set_f),
    .set_i (set_i),
    .f_mask(f_mask),
    .i_mask(i_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      take_q <= 1'b0;
      code_q <= EXC_NONE;
    end else begin
      take_q <= entry;
      if (entry) begin
        busy_q <= 1'b1;
        code_q <= winner;
      end else if (busy_q && ack) begin
        busy_q <= 1'b0;
        code_q <= EXC_NONE;
      end
    end
  end

  assign take     = take_q;
  assign mode_req = busy_q;
  assign exc_code = code_q;
  assign ret_adj  = ret_value(busy_q);

  // R9: entry pulse is one cycle wide
  p_take_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  // R9: request and code hold until acknowledged
  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && !ack) |=> (mode_req && $stable(exc_code)));
  // R9: no new entry while a switch is pending
  p_no_reentry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req |=> !take);
  // R6: an eligible fast line at an idle boundary always wins
  p_fast_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !mode_req && lvl[LINE_FAST] && !f_mask) |=> (take && exc_code == EXC_FAST));
  // R5: a masked line is never the one taken
  p_masked_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && exc_code == EXC_FAST) |-> $past(!f_mask));
  p_masked_norm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && exc_code == EXC_NORM) |-> $past(!i_mask && lvl[LINE_NORM]));
  // R2: entry only at an instruction boundary
  p_boundary_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(eoi));
  // R10: return adjustment present while the switch is pending
  p_ret_adj_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req |-> (ret_adj == RET_VAL));

endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_req_n = 1'b1, norm_req_n = 1'b1, sync_mode = 1'b1;
  logic eoi = 1'b0, priv = 1'b0, mask_wr = 1'b0, ack = 1'b0;
  logic [1:0] mask_wdata = 2'b00;
  logic take, mode_req, f_mask, i_mask;
  logic [1:0] exc_code;
  logic [3:0] ret_adj;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .fast_req_n(fast_req_n), .norm_req_n(norm_req_n),
    .sync_mode(sync_mode), .eoi(eoi), .priv(priv), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .ack(ack), .take(take), .exc_code(exc_code),
    .mode_req(mode_req), .ret_adj(ret_adj), .f_mask(f_mask), .i_mask(i_mask)
  );

  // Behavioural reference: history of line levels plus a pending-switch flag
  int m_hist_fast[$];
  int m_hist_norm[$];
  int m_f = 1, m_i = 1, m_busy = 0, m_take = 0, m_code = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hist_fast = {0};
      m_hist_norm = {0};
      m_f = 1; m_i = 1; m_busy = 0; m_take = 0; m_code = 0;
    end else begin
      int fl, nl, fire;
      fl = sync_mode ? int'(!fast_req_n) : m_hist_fast[$];
      nl = sync_mode ? int'(!norm_req_n) : m_hist_norm[$];
      fire = 0;
      if (eoi && !m_busy) begin
        if (fl && !m_f)      fire = 2;
        else if (nl && !m_i) fire = 1;
      end
      m_take = (fire != 0);
      if (fire != 0) begin
        m_busy = 1; m_code = fire;
      end else if (m_busy && ack) begin
        m_busy = 0; m_code = 0;
      end
      if (mask_wr && priv) begin
        m_f = mask_wdata[1]; m_i = mask_wdata[0];
      end
      if (fire == 2) m_f = 1;
      if (fire != 0) m_i = 1;
      m_hist_fast.push_back(int'(!fast_req_n));
      m_hist_norm.push_back(int'(!norm_req_n));
      if (m_hist_fast.size() > 4) void'(m_hist_fast.pop_front());
      if (m_hist_norm.size() > 4) void'(m_hist_norm.pop_front());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 take", int'(take), m_take);
      chk("R6 exc_code", int'(exc_code), m_code);
      chk("R9 mode_req", int'(mode_req), m_busy);
      chk("R7 f_mask", int'(f_mask), m_f);
      chk("R7 i_mask", int'(i_mask), m_i);
      chk("R10 ret_adj", int'(ret_adj), m_busy ? 4 : 0);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    fast_req_n = 1'b1; norm_req_n = 1'b1; eoi = 1'b0;
    mask_wr = 1'b0; ack = 1'b0;
  endtask

  task automatic wr_masks(input logic [1:0] v);
    idle(); priv = 1'b1; mask_wr = 1'b1; mask_wdata = v;
    cyc(); idle();
  endtask

  task automatic do_ack();
    idle(); ack = 1'b1; cyc(); idle(); cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 take", int'(take), 0);
    chk("R1 mode_req", int'(mode_req), 0);
    chk("R1 exc_code", int'(exc_code), 0);
    chk("R1 ret_adj", int'(ret_adj), 0);
    chk("R1 f_mask", int'(f_mask), 1);
    chk("R1 i_mask", int'(i_mask), 1);

    // R8 user-mode write ignored, privileged write applied
    sync_mode = 1'b1;
    idle(); priv = 1'b0; mask_wr = 1'b1; mask_wdata = 2'b00; cyc(); idle();
    chk("R8 user f", int'(f_mask), 1);
    chk("R8 user i", int'(i_mask), 1);
    wr_masks(2'b00);
    chk("R8 priv f", int'(f_mask), 0);
    chk("R8 priv i", int'(i_mask), 0);

    // R2 request level without eoi
    fast_req_n = 1'b0; cyc();
    chk("R2 no eoi", int'(take), 0);
    // R3 synchronous mode: same-cycle request and eoi
    eoi = 1'b1; cyc();
    chk("R3 take", int'(take), 1);
    chk("R6 fast code", int'(exc_code), 2);
    chk("R7 fast f", int'(f_mask), 1);
    chk("R7 fast i", int'(i_mask), 1);
    chk("R10 ret", int'(ret_adj), 4);
    eoi = 1'b0; cyc();
    chk("R9 pulse", int'(take), 0);
    chk("R9 held", int'(mode_req), 1);
    wr_masks(2'b00);
    fast_req_n = 1'b0; eoi = 1'b1; cyc();
    chk("R9 busy no take", int'(take), 0);
    do_ack();
    chk("R9 acked", int'(mode_req), 0);
    chk("R10 ret clear", int'(ret_adj), 0);
    idle(); ack = 1'b1; cyc(); idle();
    chk("R9 stray ack", int'(mode_req), 0);

    // R5 masked fast, normal taken; R7 normal leaves F
    wr_masks(2'b10);
    fast_req_n = 1'b0; eoi = 1'b1; cyc();
    chk("R5 fast masked", int'(take), 0);
    norm_req_n = 1'b0; cyc();
    chk("R5 normal taken", int'(take), 1);
    chk("R5 normal code", int'(exc_code), 1);
    do_ack();
    wr_masks(2'b00);
    norm_req_n = 1'b0; eoi = 1'b1; cyc();
    chk("R7 norm f", int'(f_mask), 0);
    chk("R7 norm i", int'(i_mask), 1);
    do_ack();
    norm_req_n = 1'b0; eoi = 1'b1; cyc();
    chk("R5 i masked", int'(take), 0);

    // R6 simultaneous requests
    wr_masks(2'b00);
    fast_req_n = 1'b0; norm_req_n = 1'b0; eoi = 1'b1; cyc();
    chk("R6 both take", int'(take), 1);
    chk("R6 both code", int'(exc_code), 2);
    do_ack();

    // R4 asynchronous mode adds one cycle
    sync_mode = 1'b0;
    wr_masks(2'b00);
    cyc();
    fast_req_n = 1'b0; eoi = 1'b1; cyc();
    chk("R4 first edge", int'(take), 0);
    cyc();
    chk("R4 second edge", int'(take), 1);
    chk("R4 code", int'(exc_code), 2);
    do_ack(); cyc(); cyc();
    sync_mode = 1'b1;

    // R11 write and entry on the same edge
    wr_masks(2'b00);
    norm_req_n = 1'b0; eoi = 1'b1; priv = 1'b1; mask_wr = 1'b1; mask_wdata = 2'b00;
    cyc(); idle();
    chk("R11 take", int'(take), 1);
    chk("R11 i wins", int'(i_mask), 1);
    chk("R11 f written", int'(f_mask), 0);
    do_ack();

    // Random traffic compared by the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 5) == 0) fast_req_n = ~fast_req_n;
      if ($urandom_range(0, 4) == 0) norm_req_n = ~norm_req_n;
      eoi = ($urandom_range(0, 2) == 0);
      priv = $urandom_range(0, 1);
      mask_wr = ($urandom_range(0, 5) == 0);
      mask_wdata = 2'($urandom_range(0, 3));
      ack = mode_req ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 9) == 0);
      if (n % 500 == 499) begin
        idle(); cyc(); cyc();
        sync_mode = ~sync_mode;
        cyc();
      end
      cyc();
    end
    idle(); cyc();
    finish_run();
  end

endmodule